// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block holds the memory operations that an out-of-order core has dispatched but not yet retired, kept in program order in a ring of slots. Dispatch offers one operation per cycle: a load, a store, or one of three barrier kinds. It also says whether the operation's source operands are already available. The block returns the slot tag it assigned. Operands that arrive later are signalled with a wake pulse that carries the tag. Every cycle the block picks at most one slot whose operation may start under a relaxed ordering policy, and it presents that slot on the grant outputs. The execution side reports completion with a done pulse. Completed slots are freed strictly from the oldest end of the ring.

Each slot runs a small state machine. The states are EMPTY, WAIT (operands missing), READY, ISSUED and DONE. The transitions are ALLOC (EMPTY to WAIT, or to READY when operands are available), WAKE (WAIT to READY), GRANT (READY to ISSUED), COMPLETE (ISSUED to DONE) and RETIRE (DONE to EMPTY, taken only by the oldest slot). Loads may pass older loads. Loads may pass older stores only while the static no-alias input is high. Stores never pass older loads or stores. A barrier starts only from the oldest slot. Load barriers fence younger loads and store barriers fence younger stores until the barrier completes. The load and store occupancy limits are parameters, and a value of zero for either selects a built-in default. Full flags tell dispatch to stop offering that kind of operation.

Top module: `mem_order_queue`

## Requirements
- R1: After reset, grant_valid, ld_full, st_full and ord_full are all low and alloc_tag is 0.
- R2: Accepted operations receive tags 0, 1, 2 … in order of acceptance, wrapping from ENTRIES-1 back to 0; alloc_tag always shows the tag that the next accepted operation will get.
- R3: A load may be granted while an older load is still waiting for its operands or for a grant.
- R4: A store is not granted while any older load or store is in WAIT or READY, whatever the value of no_alias.
- R5: A load is not granted while an older store is in WAIT or READY if no_alias is 0; if no_alias is 1 that store does not hold it back.
- R6: A barrier (alloc_kind 2 = load barrier, 3 = store barrier, 4 = full barrier) is granted only while it occupies the oldest slot.
- R7: A load is held while any older load barrier or full barrier has not reached DONE; a load barrier does not hold back a younger store.
- R8: A store is held while any older store barrier or full barrier has not reached DONE; a store barrier does not hold back a younger load.
- R9: At most one slot is granted per cycle, and it is the oldest eligible one. A granted slot becomes ISSUED on the next clock edge and is not granted again.
- R10: With LQ_DEPTH = SQ_DEPTH = 0, the load and store limits are 4 each. ld_full rises once 4 loads are held, st_full once 4 stores are held, and ord_full once all ENTRIES slots are held. An offer of a load while ld_full is high, of a store while st_full is high, or of a barrier while ord_full is high is ignored and consumes no tag (alloc_kind 0 = load, 1 = store).
- R11: A slot in DONE is freed only when it is the oldest slot, one per cycle, on the edge after it becomes or stays oldest; the full flags drop only after that edge.
- R12: A slot allocated with alloc_rdy low is not granted until a wake pulse names its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| no_alias | input | 1 | Static setting: loads may pass older pending stores when high |
| alloc_valid | input | 1 | Dispatch offers an operation this cycle |
| alloc_kind | input | 3 | 0 load, 1 store, 2 load barrier, 3 store barrier, 4 full barrier |
| alloc_rdy | input | 1 | Operands of the offered operation are available |
| alloc_tag | output | TW | Tag for the next accepted operation |
| wake_valid | input | 1 | Operands of a waiting slot have become available |
| wake_tag | input | TW | Slot named by wake_valid |
| done_valid | input | 1 | An issued slot has completed |
| done_tag | input | TW | Slot named by done_valid |
| grant_valid | output | 1 | A slot starts execution this cycle |
| grant_tag | output | TW | Slot being granted |
| ld_full | output | 1 | No load can be accepted |
| st_full | output | 1 | No store can be accepted |
| ord_full | output | 1 | Every slot is held |

## Verification
The bench places a ready operation behind a waiting one of each kind pairing. It checks that load-over-load passing happens (R3) and that store passing never does (R4). A design that treated the queue as a plain FIFO would stall in the first case, and one that ignored store ordering would grant the store early. The no-alias setting is exercised both ways on the same store-then-load pattern; swapping its polarity shows up at once. Barriers are checked for waiting until they are oldest and for fencing only their own kind until they complete, so a design that released the fence at grant rather than at completion, or that fenced both kinds, grants on the wrong cycle. It also fills the load and store limits with the default-depth setting, then frees a younger completed slot before an older one: a design that freed on completion rather than in order would drop ld_full one edge too soon and hand out a wrong tag after the wrap.

// File: rtl/lsoq_pkg.sv
package lsoq_pkg;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_LBAR  = 3'd2,
        K_SBAR  = 3'd3,
        K_FBAR  = 3'd4
    } op_kind_e;

    typedef enum logic [2:0] {
        S_EMPTY,
        S_WAIT,
        S_READY,
        S_ISSUED,
        S_DONE
    } slot_state_e;

    function automatic logic fences_loads(op_kind_e k);
        return (k == K_LBAR) || (k == K_FBAR);
    endfunction

    function automatic logic fences_stores(op_kind_e k);
        return (k == K_SBAR) || (k == K_FBAR);
    endfunction

    function automatic logic is_barrier(op_kind_e k);
        return (k == K_LBAR) || (k == K_SBAR) || (k == K_FBAR);
    endfunction

endpackage

// File: rtl/lsoq_slot.sv
module lsoq_slot
    import lsoq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alloc_hit,
    input  op_kind_e    alloc_kind,
    input  logic        alloc_rdy,
    input  logic        wake_hit,
    input  logic        grant_hit,
    input  logic        done_hit,
    input  logic        retire_hit,
    output slot_state_e st_o,
    output op_kind_e    kind_o
);

    slot_state_e st_q, st_d;
    op_kind_e    kind_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_EMPTY:  if (alloc_hit)  st_d = alloc_rdy ? S_READY : S_WAIT;
            S_WAIT:   if (wake_hit)   st_d = S_READY;
            S_READY:  if (grant_hit)  st_d = S_ISSUED;
            S_ISSUED: if (done_hit)   st_d = S_DONE;
            S_DONE:   if (retire_hit) st_d = S_EMPTY;
            default:                  st_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_EMPTY;
            kind_q <= K_LOAD;
        end else begin
            st_q <= st_d;
            if (alloc_hit && st_q == S_EMPTY) kind_q <= alloc_kind;
        end
    end

    always_comb begin
        st_o   = st_q;
        kind_o = kind_q;
    end

endmodule

// File: rtl/lsoq_gate.sv
module lsoq_gate
    import lsoq_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int TW = $clog2(ENTRIES)
) (
    input  slot_state_e      st [ENTRIES],
    input  op_kind_e         kd [ENTRIES],
    input  logic [TW-1:0]    head,
    input  logic             no_alias,
    output logic [ENTRIES-1:0] elig
);

    logic [TW-1:0] age_j, age_i;
    logic          blk, pend, live;

    always_comb begin
        elig  = '0;
        age_j = '0;
        age_i = '0;
        blk   = 1'b0;
        pend  = 1'b0;
        live  = 1'b0;
        for (int j = 0; j < ENTRIES; j++) begin
            age_j = TW'(j) - head;
            blk   = 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                age_i = TW'(i) - head;
                pend  = (st[i] == S_WAIT) || (st[i] == S_READY);
                live  = (st[i] != S_EMPTY) && (st[i] != S_DONE);
                if (age_i < age_j) begin
                    if (kd[j] == K_LOAD) begin
                        if (fences_loads(kd[i]) && live) blk = 1'b1;
                        if (kd[i] == K_STORE && pend && !no_alias) blk = 1'b1;
                    end else if (kd[j] == K_STORE) begin
                        if (fences_stores(kd[i]) && live) blk = 1'b1;
                        if ((kd[i] == K_LOAD || kd[i] == K_STORE) && pend) blk = 1'b1;
                    end
                end
            end
            if (is_barrier(kd[j]) && TW'(j) != head) blk = 1'b1;
            elig[j] = (st[j] == S_READY) && !blk;
        end
    end

endmodule

// File: rtl/lsoq_pick.sv
module lsoq_pick #(
    parameter int ENTRIES = 8,
    localparam int TW = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] elig,
    input  logic [TW-1:0]      head,
    output logic               vld,
    output logic [TW-1:0]      tag
);

    logic [TW-1:0] idx;

    always_comb begin
        vld = 1'b0;
        tag = '0;
        idx = '0;
        for (int a = ENTRIES - 1; a >= 0; a--) begin
            idx = head + TW'(a);
            if (elig[idx]) begin
                vld = 1'b1;
                tag = idx;
            end
        end
    end

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import lsoq_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int LQ_DEPTH   = 0,
    parameter int SQ_DEPTH   = 0,
    parameter int LQ_DEFAULT = 4,
    parameter int SQ_DEFAULT = 4,
    localparam int TW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          no_alias,
    input  logic          alloc_valid,
    input  logic [2:0]    alloc_kind,
    input  logic          alloc_rdy,
    output logic [TW-1:0] alloc_tag,
    input  logic          wake_valid,
    input  logic [TW-1:0] wake_tag,
    input  logic          done_valid,
    input  logic [TW-1:0] done_tag,
    output logic          grant_valid,
    output logic [TW-1:0] grant_tag,
    output logic          ld_full,
    output logic          st_full,
    output logic          ord_full
);

    localparam int CW     = TW + 1;
    localparam int LQ_EFF = (LQ_DEPTH == 0) ? LQ_DEFAULT : LQ_DEPTH;
    localparam int SQ_EFF = (SQ_DEPTH == 0) ? SQ_DEFAULT : SQ_DEPTH;
    localparam int LQ_CAP = (LQ_EFF > ENTRIES) ? ENTRIES : LQ_EFF;
    localparam int SQ_CAP = (SQ_EFF > ENTRIES) ? ENTRIES : SQ_EFF;

    op_kind_e    akind;
    slot_state_e slot_st [ENTRIES];
    op_kind_e    slot_kd [ENTRIES];
    logic [ENTRIES-1:0] elig;

    logic [TW-1:0] head_q, tail_q;
    logic [CW-1:0] occ_q, ldc_q, stc_q;
    logic          alloc_ok, a_ld, a_st, retire, r_ld, r_st;

    assign akind = op_kind_e'(alloc_kind);
    assign a_ld  = (akind == K_LOAD);
    assign a_st  = (akind == K_STORE);

    always_comb begin
        ord_full = (occ_q == CW'(ENTRIES));
        ld_full  = ord_full || (ldc_q == CW'(LQ_CAP));
        st_full  = ord_full || (stc_q == CW'(SQ_CAP));
        alloc_tag = tail_q;
        if (a_ld)                   alloc_ok = alloc_valid && !ld_full;
        else if (a_st)              alloc_ok = alloc_valid && !st_full;
        else if (is_barrier(akind)) alloc_ok = alloc_valid && !ord_full;
        else                        alloc_ok = 1'b0;
        retire = (slot_st[head_q] == S_DONE);
        r_ld   = retire && (slot_kd[head_q] == K_LOAD);
        r_st   = retire && (slot_kd[head_q] == K_STORE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
            ldc_q  <= '0;
            stc_q  <= '0;
        end else begin
            tail_q <= tail_q + TW'(alloc_ok);
            head_q <= head_q + TW'(retire);
            occ_q  <= occ_q + CW'(alloc_ok) - CW'(retire);
            ldc_q  <= ldc_q + CW'(alloc_ok && a_ld) - CW'(r_ld);
            stc_q  <= stc_q + CW'(alloc_ok && a_st) - CW'(r_st);
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        lsoq_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_hit  (alloc_ok && tail_q == TW'(g)),
            .alloc_kind (akind),
            .alloc_rdy  (alloc_rdy),
            .wake_hit   (wake_valid && wake_tag == TW'(g)),
            .grant_hit  (grant_valid && grant_tag == TW'(g)),
            .done_hit   (done_valid && done_tag == TW'(g)),
            .retire_hit (retire && head_q == TW'(g)),
            .st_o       (slot_st[g]),
            .kind_o     (slot_kd[g])
        );
    end

    lsoq_gate #(.ENTRIES(ENTRIES)) u_gate (
        .st       (slot_st),
        .kd       (slot_kd),
        .head     (head_q),
        .no_alias (no_alias),
        .elig     (elig)
    );

    lsoq_pick #(.ENTRIES(ENTRIES)) u_pick (
        .elig (elig),
        .head (head_q),
        .vld  (grant_valid),
        .tag  (grant_tag)
    );

endmodule

// File: rtl/lsoq_chk.sv
module lsoq_chk
    import lsoq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LQ_CAP  = 4,
    parameter int SQ_CAP  = 4,
    localparam int TW = $clog2(ENTRIES),
    localparam int CW = TW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic [2:0]    alloc_kind,
    input logic          ld_full,
    input logic [TW-1:0] tail_q,
    input logic [TW-1:0] head_q,
    input logic [CW-1:0] ldc_q,
    input logic [CW-1:0] stc_q,
    input logic          grant_valid,
    input logic [TW-1:0] grant_tag,
    input slot_state_e   st [ENTRIES],
    input op_kind_e      kd [ENTRIES]
);

    // R9: a granted slot is one that is ready
    p_grant_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> st[grant_tag] == S_READY);

    // R9: the granted slot has left READY on the next edge
    p_grant_issues_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> st[$past(grant_tag)] == S_ISSUED);

    // R6: barriers start only from the oldest slot
    p_bar_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && is_barrier(kd[grant_tag])) |-> grant_tag == head_q);

    // R10: load and store occupancy stay within their limits
    p_ld_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ldc_q <= CW'(LQ_CAP));
    p_st_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stc_q <= CW'(SQ_CAP));

    // R10: a load offered while full takes no tag
    p_full_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_kind == 3'd0 && ld_full) |=> $stable(tail_q));

endmodule

bind mem_order_queue lsoq_chk #(
    .ENTRIES (ENTRIES),
    .LQ_CAP  (LQ_CAP),
    .SQ_CAP  (SQ_CAP)
) u_lsoq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_kind  (alloc_kind),
    .ld_full     (ld_full),
    .tail_q      (tail_q),
    .head_q      (head_q),
    .ldc_q       (ldc_q),
    .stc_q       (stc_q),
    .grant_valid (grant_valid),
    .grant_tag   (grant_tag),
    .st          (slot_st),
    .kd          (slot_kd)
);

// File: tb/mem_order_queue_tb_top.sv
`timescale 1ns/1ps
module mem_order_queue_tb_top;

    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          no_alias = 1'b1;
    logic          alloc_valid = 1'b0;
    logic [2:0]    alloc_kind = '0;
    logic          alloc_rdy = 1'b0;
    logic [TW-1:0] alloc_tag;
    logic          wake_valid = 1'b0;
    logic [TW-1:0] wake_tag = '0;
    logic          done_valid = 1'b0;
    logic [TW-1:0] done_tag = '0;
    logic          grant_valid;
    logic [TW-1:0] grant_tag;
    logic          ld_full, st_full, ord_full;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mem_order_queue dut_i (
        .clk(clk), .rst_n(rst_n), .no_alias(no_alias),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_rdy(alloc_rdy),
        .alloc_tag(alloc_tag),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .grant_valid(grant_valid), .grant_tag(grant_tag),
        .ld_full(ld_full), .st_full(st_full), .ord_full(ord_full)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic see_grant(input string req, input bit v, input int tag);
        chk(req, "grant_valid", int'(grant_valid), int'(v));
        if (v) chk(req, "grant_tag", int'(grant_tag), tag);
    endtask

    task automatic do_reset(input bit na);
        rst_n = 1'b0;
        no_alias = na;
        alloc_valid = 1'b0;
        wake_valid = 1'b0;
        done_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put(input int k, input bit r, output int tag);
        alloc_valid = 1'b1;
        alloc_kind = 3'(k);
        alloc_rdy = r;
        tag = int'(alloc_tag);
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic wake(input int t);
        wake_valid = 1'b1;
        wake_tag = TW'(t);
        @(negedge clk);
        wake_valid = 1'b0;
    endtask

    task automatic finish_op(input int t);
        done_valid = 1'b1;
        done_tag = TW'(t);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        see_grant("R1", 1'b0, 0);
        chk("R1", "ld_full", int'(ld_full), 0);
        chk("R1", "st_full", int'(st_full), 0);
        chk("R1", "ord_full", int'(ord_full), 0);
        chk("R1", "alloc_tag", int'(alloc_tag), 0);
    endtask

    task automatic t_load_pass();
        int a, b;
        do_reset(1'b1);
        put(0, 1'b0, a);
        see_grant("R12", 1'b0, 0);
        put(0, 1'b1, b);
        chk("R2", "first tag", a, 0);
        chk("R2", "second tag", b, 1);
        see_grant("R3", 1'b1, 1);
        tick();
        see_grant("R12", 1'b0, 0);
        wake(0);
        see_grant("R12", 1'b1, 0);
    endtask

    task automatic t_store_order();
        int a, b;
        do_reset(1'b1);
        put(0, 1'b0, a);
        put(1, 1'b1, b);
        see_grant("R4", 1'b0, 0);
        wake(0);
        see_grant("R4", 1'b1, 0);
        tick();
        see_grant("R4", 1'b1, 1);
        tick();
        see_grant("R9", 1'b0, 0);
        do_reset(1'b1);
        put(1, 1'b0, a);
        put(1, 1'b1, b);
        see_grant("R4", 1'b0, 0);
        wake(0);
        see_grant("R4", 1'b1, 0);
        tick();
        see_grant("R4", 1'b1, 1);
    endtask

    task automatic t_alias();
        int a, b;
        do_reset(1'b0);
        put(1, 1'b0, a);
        put(0, 1'b1, b);
        see_grant("R5", 1'b0, 0);
        do_reset(1'b1);
        put(1, 1'b0, a);
        put(0, 1'b1, b);
        see_grant("R5", 1'b1, 1);
    endtask

    task automatic t_barrier_head();
        int a, b;
        do_reset(1'b1);
        put(0, 1'b0, a);
        put(4, 1'b1, b);
        see_grant("R6", 1'b0, 0);
        wake(0);
        see_grant("R6", 1'b1, 0);
        tick();
        see_grant("R6", 1'b0, 0);
        finish_op(0);
        see_grant("R6", 1'b0, 0);
        tick();
        see_grant("R6", 1'b1, 1);
    endtask

    task automatic t_load_fence();
        int a, b, c;
        do_reset(1'b1);
        put(2, 1'b1, a);
        see_grant("R7", 1'b1, 0);
        put(1, 1'b1, b);
        see_grant("R7", 1'b1, 1);
        put(0, 1'b1, c);
        see_grant("R7", 1'b0, 0);
        finish_op(0);
        see_grant("R7", 1'b1, 2);
    endtask

    task automatic t_store_fence();
        int a, b, c;
        do_reset(1'b1);
        put(3, 1'b1, a);
        see_grant("R8", 1'b1, 0);
        put(0, 1'b1, b);
        see_grant("R8", 1'b1, 1);
        put(1, 1'b1, c);
        see_grant("R8", 1'b0, 0);
        finish_op(0);
        see_grant("R8", 1'b1, 2);
    endtask

    task automatic t_oldest();
        int a, b, c;
        do_reset(1'b1);
        put(2, 1'b1, a);
        see_grant("R9", 1'b1, 0);
        put(0, 1'b1, b);
        see_grant("R9", 1'b0, 0);
        put(0, 1'b1, c);
        see_grant("R9", 1'b0, 0);
        finish_op(0);
        see_grant("R9", 1'b1, 1);
        tick();
        see_grant("R9", 1'b1, 2);
        tick();
        see_grant("R9", 1'b0, 0);
    endtask

    task automatic t_capacity_retire();
        int t;
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) put(0, 1'b0, t);
        chk("R10", "ld_full", int'(ld_full), 1);
        chk("R10", "st_full", int'(st_full), 0);
        put(0, 1'b0, t);
        put(1, 1'b0, t);
        chk("R10", "store tag after ignored load", t, 4);
        for (int i = 0; i < 3; i++) put(1, 1'b0, t);
        chk("R10", "st_full", int'(st_full), 1);
        chk("R10", "ord_full", int'(ord_full), 1);
        put(4, 1'b1, t);
        chk("R10", "ord_full after ignored barrier", int'(ord_full), 1);
        see_grant("R10", 1'b0, 0);
        chk("R2", "wrapped alloc_tag", int'(alloc_tag), 0);
        wake(1);
        see_grant("R3", 1'b1, 1);
        tick();
        finish_op(1);
        tick();
        chk("R11", "ld_full with younger done", int'(ld_full), 1);
        wake(0);
        see_grant("R11", 1'b1, 0);
        tick();
        finish_op(0);
        chk("R11", "ld_full on done edge", int'(ld_full), 1);
        tick();
        chk("R11", "ld_full after retire", int'(ld_full), 0);
        chk("R11", "ord_full after retire", int'(ord_full), 0);
        tick();
        put(0, 1'b1, t);
        chk("R2", "tag after wrap", t, 0);
        see_grant("R5", 1'b1, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_load_pass();
        t_store_order();
        t_alias();
        t_barrier_head();
        t_load_fence();
        t_store_fence();
        t_oldest();
        t_capacity_retire();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule